// File: doc/BRIEF.md
# Flash Bulk Programming Sequencer

This block sits on the host side of a parallel NOR flash device. It writes a run of consecutive words that arrive on a ready/valid stream. One start pulse carries a base address and a word count. The sequencer puts the device into its unlock-bypass state with a three-write preamble. In that state each word costs only two bus writes: a program command, then the address with the data.

After each word the sequencer polls the device. It compares bit 7 of the returned status with bit 7 of the data it just wrote, and a match means the device's internal program algorithm has finished. It then reads the word back in full and compares it with the data. Each word that verifies moves the sequencer on to the next address.

After the last word, a verify failure or a poll timeout, the sequencer issues the two-write bypass exit so the device returns to normal reads. It then pulses `done`. The error outputs say which condition stopped the job and at which address. The bus is a plain strobe interface: a write happens in every cycle `bus_we` is high, and the read data for a `bus_re` cycle is presented on `bus_rdata` in the following cycle.

Top module: `flash_burst_prog`

## Requirements
- R1: `start` is acted on only while the block is idle. `base_addr` and `word_count` are captured on that clock edge. A `start` pulse, or a change of `base_addr` or `word_count`, while a job is running does not change that job's bus traffic.
- R2: After a start with a nonzero count, the first three bus cycles are consecutive writes: AAh to 555h, then 55h to 2AAh, then 20h to 555h. Command bytes sit in the low byte of `bus_wdata` and the upper bits are zero.
- R3: `s_ready` is high only while the block is waiting for the next word. When a word is taken, the next cycle writes A0h to the word's address and the cycle after that writes the word itself to the same address.
- R4: Status polling reads the current word address. A poll ends when bit 7 of the returned data equals bit 7 of the word, and a full read-back of the same address follows.
- R5: If the read-back differs from the word, `err_verify` is set, `err_addr` takes the word's address, no further words are programmed, and the exit pair is issued.
- R6: Words are programmed at base, base+1, and so on, for `word_count` words. A new word is requested only after the previous word has verified.
- R7: The exit pair is a write of 90h and then a write of 00h, in consecutive cycles, both at address 0. `done` is high for exactly one cycle, in the cycle after the 00h write, and the block is idle in the following cycle.
- R8: After POLL_MAX consecutive polls that do not match, `err_timeout` is set, `err_addr` takes the word's address, and the exit pair and `done` follow.
- R9: A start with `word_count` equal to zero makes no bus cycle and raises `done` in the cycle after the start.
- R10: The error outputs are cleared by an accepted start and otherwise hold their value. At most one error flag is set at a time.
- R11: After reset the block is idle, with no strobe, no ready, no `done` and no error. `bus_we` and `bus_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a job; taken only when idle |
| base_addr | input | ADDR_W | First word address of the job |
| word_count | input | COUNT_W | Number of words to program |
| s_valid | input | 1 | Stream word present |
| s_ready | output | 1 | Block is waiting for a word |
| s_data | input | DATA_W | Stream word |
| bus_we | output | 1 | Device write cycle |
| bus_re | output | 1 | Device read cycle |
| bus_addr | output | ADDR_W | Device address |
| bus_wdata | output | DATA_W | Device write data |
| bus_rdata | input | DATA_W | Device read data, valid the cycle after `bus_re` |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| err_verify | output | 1 | Read-back mismatch stopped the job |
| err_timeout | output | 1 | Poll limit reached |
| err_addr | output | ADDR_W | Word address of the failure |

## Verification
The cycle-level rules are checked on every clock edge:
- write and read strobes are never high together;
- the command write follows a taken word, and the data write follows the command;
- the first preamble write follows an accepted start;
- a zero-count start ends at once;
- `done` is a one-cycle pulse that returns the block to idle;
- the error outputs stay still while the block is idle.

Only the bench scenarios can show the behaviours that need a device model behind the bus:
- the whole write sequence and the addresses it uses, over a sweep of bases, counts and program latencies;
- the contents of memory after a job;
- that polling stays on the word address;
- the exact number of polls before a timeout;
- that programming stops at the failing word.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_UNL_A,
      ST_UNL_B,
      ST_BYP_ENT,
      ST_WAIT_WORD,
      ST_PGM_CMD,
      ST_PGM_DATA,
      ST_POLL_RD,
      ST_POLL_CHK,
      ST_VER_RD,
      ST_VER_CHK,
      ST_EXIT_A,
      ST_EXIT_B,
      ST_FIN
   } seq_state_t;

   // Device command bytes (low byte of the data bus)
   localparam logic [7:0] CMD_UNL_1  = 8'hAA;
   localparam logic [7:0] CMD_UNL_2  = 8'h55;
   localparam logic [7:0] CMD_BYPASS = 8'h20;
   localparam logic [7:0] CMD_PROG   = 8'hA0;
   localparam logic [7:0] CMD_EXIT_1 = 8'h90;
   localparam logic [7:0] CMD_EXIT_2 = 8'h00;

   // Unlock addresses need 11 address bits
   localparam logic [10:0] UNL_ADDR_1 = 11'h555;
   localparam logic [10:0] UNL_ADDR_2 = 11'h2AA;

endpackage

// File: rtl/fbp_addr_track.sv
module fbp_addr_track #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned COUNT_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic [ADDR_W-1:0]  base,
   input  logic [COUNT_W-1:0] count,
   output logic [ADDR_W-1:0]  cur_addr,
   output logic               last_word
);

   logic [COUNT_W-1:0] left_q;

   generate
      if (COUNT_W < 1) begin : g_bad_cw
         $error("fbp_addr_track: COUNT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         left_q   <= '0;
      end else if (load) begin
         cur_addr <= base;
         left_q   <= count;
      end else if (step) begin
         cur_addr <= cur_addr + ADDR_W'(1);
         left_q   <= left_q - COUNT_W'(1);
      end
   end

   assign last_word = (left_q == COUNT_W'(1));

endmodule

// File: rtl/fbp_poll_timer.sv
module fbp_poll_timer #(
   parameter int unsigned POLL_MAX = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic miss,
   output logic expired
);

   localparam int unsigned CNT_W = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;

   generate
      if (POLL_MAX < 2) begin : g_bad_pm
         $error("fbp_poll_timer: POLL_MAX must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else if (miss)  cnt_q <= cnt_q + CNT_W'(1);
   end

   // The POLL_MAX-th consecutive miss
   assign expired = miss && (cnt_q == CNT_W'(POLL_MAX - 1));

endmodule

// File: rtl/fbp_bus_mux.sv
module fbp_bus_mux
   import fbp_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16
) (
   input  seq_state_t        cur_state,
   input  logic [ADDR_W-1:0] word_addr,
   input  logic [DATA_W-1:0] word_data,
   output logic              we,
   output logic              re,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata
);

   logic [7:0]        cmd;
   logic [DATA_W-1:0] cmd_ext;
   logic              use_data;

   always_comb begin
      we       = 1'b0;
      re       = 1'b0;
      addr     = '0;
      cmd      = CMD_EXIT_2;
      use_data = 1'b0;
      case (cur_state)
         ST_UNL_A: begin
            we   = 1'b1;
            addr = ADDR_W'(UNL_ADDR_1);
            cmd  = CMD_UNL_1;
         end
         ST_UNL_B: begin
            we   = 1'b1;
            addr = ADDR_W'(UNL_ADDR_2);
            cmd  = CMD_UNL_2;
         end
         ST_BYP_ENT: begin
            we   = 1'b1;
            addr = ADDR_W'(UNL_ADDR_1);
            cmd  = CMD_BYPASS;
         end
         ST_PGM_CMD: begin
            we   = 1'b1;
            addr = word_addr;
            cmd  = CMD_PROG;
         end
         ST_PGM_DATA: begin
            we       = 1'b1;
            addr     = word_addr;
            use_data = 1'b1;
         end
         ST_POLL_RD, ST_VER_RD: begin
            re   = 1'b1;
            addr = word_addr;
         end
         ST_EXIT_A: begin
            we  = 1'b1;
            cmd = CMD_EXIT_1;
         end
         ST_EXIT_B: begin
            we  = 1'b1;
            cmd = CMD_EXIT_2;
         end
         default: ;
      endcase
   end

   generate
      if (DATA_W == 8) begin : g_narrow
         assign cmd_ext = cmd;
      end else begin : g_wide
         assign cmd_ext = {{(DATA_W-8){1'b0}}, cmd};
      end
   endgenerate

   assign wdata = use_data ? word_data : cmd_ext;

endmodule

// File: rtl/flash_burst_prog.sv
module flash_burst_prog
   import fbp_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned COUNT_W    = 12,
   parameter int unsigned POLL_MAX   = 4096,
   parameter int unsigned STATUS_BIT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  base_addr,
   input  logic [COUNT_W-1:0] word_count,
   input  logic               s_valid,
   output logic               s_ready,
   input  logic [DATA_W-1:0]  s_data,
   output logic               bus_we,
   output logic               bus_re,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [DATA_W-1:0]  bus_wdata,
   input  logic [DATA_W-1:0]  bus_rdata,
   output logic               busy,
   output logic               done,
   output logic               err_verify,
   output logic               err_timeout,
   output logic [ADDR_W-1:0]  err_addr
);

   generate
      if (ADDR_W < 11) begin : g_bad_aw
         $error("flash_burst_prog: ADDR_W must be at least 11");
      end
      if (DATA_W < 8) begin : g_bad_dw
         $error("flash_burst_prog: DATA_W must be at least 8");
      end
      if (STATUS_BIT >= DATA_W) begin : g_bad_sb
         $error("flash_burst_prog: STATUS_BIT outside data bus");
      end
   endgenerate

   seq_state_t        state_q, state_d;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] cur_addr;
   logic              last_word;
   logic              job_load, word_take, addr_step;
   logic              poll_hit, poll_miss, poll_expired, verify_ok;

   assign job_load  = start && (state_q == ST_IDLE);
   assign word_take = s_valid && (state_q == ST_WAIT_WORD);
   assign poll_hit  = (bus_rdata[STATUS_BIT] == data_q[STATUS_BIT]);
   assign verify_ok = (bus_rdata == data_q);
   assign poll_miss = (state_q == ST_POLL_CHK) && !poll_hit;
   assign addr_step = (state_q == ST_VER_CHK) && verify_ok && !last_word;

   fbp_addr_track #(
      .ADDR_W  (ADDR_W),
      .COUNT_W (COUNT_W)
   ) i_addr_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (job_load),
      .step      (addr_step),
      .base      (base_addr),
      .count     (word_count),
      .cur_addr  (cur_addr),
      .last_word (last_word)
   );

   fbp_poll_timer #(
      .POLL_MAX (POLL_MAX)
   ) i_poll_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (state_q == ST_PGM_DATA),
      .miss    (poll_miss),
      .expired (poll_expired)
   );

   fbp_bus_mux #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_bus_mux (
      .cur_state (state_q),
      .word_addr (cur_addr),
      .word_data (data_q),
      .we        (bus_we),
      .re        (bus_re),
      .addr      (bus_addr),
      .wdata     (bus_wdata)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:
            if (start) state_d = (word_count == '0) ? ST_FIN : ST_UNL_A;
         ST_UNL_A:     state_d = ST_UNL_B;
         ST_UNL_B:     state_d = ST_BYP_ENT;
         ST_BYP_ENT:   state_d = ST_WAIT_WORD;
         ST_WAIT_WORD: if (s_valid) state_d = ST_PGM_CMD;
         ST_PGM_CMD:   state_d = ST_PGM_DATA;
         ST_PGM_DATA:  state_d = ST_POLL_RD;
         ST_POLL_RD:   state_d = ST_POLL_CHK;
         ST_POLL_CHK: begin
            if (poll_hit)          state_d = ST_VER_RD;
            else if (poll_expired) state_d = ST_EXIT_A;
            else                   state_d = ST_POLL_RD;
         end
         ST_VER_RD:    state_d = ST_VER_CHK;
         ST_VER_CHK: begin
            if (!verify_ok || last_word) state_d = ST_EXIT_A;
            else                         state_d = ST_WAIT_WORD;
         end
         ST_EXIT_A:    state_d = ST_EXIT_B;
         ST_EXIT_B:    state_d = ST_FIN;
         ST_FIN:       state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         data_q  <= '0;
      end else begin
         state_q <= state_d;
         if (word_take) data_q <= s_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_verify  <= 1'b0;
         err_timeout <= 1'b0;
         err_addr    <= '0;
      end else if (job_load) begin
         err_verify  <= 1'b0;
         err_timeout <= 1'b0;
         err_addr    <= '0;
      end else if ((state_q == ST_VER_CHK) && !verify_ok) begin
         err_verify <= 1'b1;
         err_addr   <= cur_addr;
      end else if (poll_miss && poll_expired) begin
         err_timeout <= 1'b1;
         err_addr    <= cur_addr;
      end
   end

   assign busy    = (state_q != ST_IDLE);
   assign done    = (state_q == ST_FIN);
   assign s_ready = (state_q == ST_WAIT_WORD);

endmodule

// File: rtl/fbp_checker.sv
module fbp_checker #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned COUNT_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic               s_valid,
   input logic               s_ready,
   input logic [DATA_W-1:0]  s_data,
   input logic [COUNT_W-1:0] word_count,
   input logic               bus_we,
   input logic               bus_re,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic               err_verify,
   input logic               err_timeout,
   input logic [ADDR_W-1:0]  err_addr
);

   AST_NO_WE_RE: assert property (@(posedge clk) disable iff (!rst_n) !(bus_we && bus_re)); // R11

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R7

   AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (busy && !bus_we && !bus_re)); // R3

   AST_CMD_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |=> (bus_we && bus_wdata == DATA_W'(8'hA0))); // R3

   AST_DATA_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |=> ##1 (bus_we && bus_wdata == $past(s_data, 2)
                                    && bus_addr == $past(bus_addr))); // R3

   AST_UNLOCK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && word_count != '0) |=>
         (bus_we && bus_addr == ADDR_W'(11'h555) && bus_wdata == DATA_W'(8'hAA))); // R2

   AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && word_count == '0) |=> (done && !bus_we && !bus_re)); // R9

   AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_verify && err_timeout)); // R10

   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !busy) |=> ($stable(err_verify) && $stable(err_timeout)
                             && $stable(err_addr))); // R10

endmodule

bind flash_burst_prog fbp_checker #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .COUNT_W (COUNT_W)
) i_fbp_checker (.*);

// File: tb/test_flash_burst_prog.sv
module test_flash_burst_prog;

   localparam int AW = 12;
   localparam int DW = 16;
   localparam int CW = 4;
   localparam int PM = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic [CW-1:0] word_count = '0;
   logic          s_valid = 1'b0;
   logic          s_ready;
   logic [DW-1:0] s_data = '0;
   logic          bus_we, bus_re;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] m_rdata = '0;
   logic          busy, done, err_verify, err_timeout;
   logic [AW-1:0] err_addr;

   always #4 clk = ~clk; // 125 MHz

   flash_burst_prog #(
      .ADDR_W   (AW),
      .DATA_W   (DW),
      .COUNT_W  (CW),
      .POLL_MAX (PM)
   ) i_flash_burst_prog (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .base_addr   (base_addr),
      .word_count  (word_count),
      .s_valid     (s_valid),
      .s_ready     (s_ready),
      .s_data      (s_data),
      .bus_we      (bus_we),
      .bus_re      (bus_re),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (m_rdata),
      .busy        (busy),
      .done        (done),
      .err_verify  (err_verify),
      .err_timeout (err_timeout),
      .err_addr    (err_addr)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   // ---------------- flash device model ----------------
   logic [DW-1:0] mem [0:63];
   logic [AW-1:0] log_a [0:31];
   logic [DW-1:0] log_d [0:31];
   int            nlog = 0;
   logic          arm = 1'b0;
   int            busy_cnt = 0;
   logic          hang_act = 1'b0;
   logic [DW-1:0] pend = '0;
   logic [AW-1:0] prog_addr = '0;
   int            bad_reads = 0;
   int            hang_reads = 0;
   logic          clr = 1'b0;
   int            m_delay = 0;
   int            stuck_sel = -1;
   int            hang_sel = -1;

   always @(posedge clk) begin
      if (clr) begin
         for (int i = 0; i < 64; i++) mem[i] <= '1;
         nlog <= 0; arm <= 1'b0; busy_cnt <= 0; hang_act <= 1'b0;
         bad_reads <= 0; hang_reads <= 0; pend <= '0; prog_addr <= '0;
      end else begin
         if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
         if (bus_re) begin
            if (bus_addr != prog_addr) bad_reads <= bad_reads + 1;
            if (hang_act) begin
               m_rdata    <= ~pend;
               hang_reads <= hang_reads + 1;
            end else if (busy_cnt > 0) m_rdata <= ~pend;
            else m_rdata <= mem[bus_addr[5:0]];
         end
         if (bus_we) begin
            if (nlog < 32) begin
               log_a[nlog] <= bus_addr;
               log_d[nlog] <= bus_wdata;
            end
            nlog <= nlog + 1;
            if (arm) begin
               arm       <= 1'b0;
               prog_addr <= bus_addr;
               pend      <= bus_wdata;
               busy_cnt  <= m_delay;
               hang_act  <= (int'(bus_addr) == hang_sel);
               mem[bus_addr[5:0]] <= (int'(bus_addr) == stuck_sel) ?
                                     (bus_wdata & ~16'h0001) : bus_wdata;
            end else if (bus_wdata == 16'h00A0) arm <= 1'b1;
         end
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   task automatic run_job(input int base, input int cnt, input int dly,
                          input int stuck_k, input int hang_k, input bit inject);
      logic [DW-1:0] wd [0:7];
      logic [AW-1:0] ea [0:31];
      logic [DW-1:0] ed [0:31];
      int  last_w, n_exp, k, done_cyc, bad_idx;
      bit  over, got_done, width_ok;
      over = 0; got_done = 0; width_ok = 0; done_cyc = -1; bad_idx = -1;
      for (int i = 0; i < 8; i++)
         wd[i] = DW'(((base * 37) + (i * 4099) + (dly * 291)) ^ 'h5A3C);
      if (stuck_k >= 0) wd[stuck_k][0] = 1'b1;

      @(negedge clk);
      m_delay   = dly;
      stuck_sel = (stuck_k >= 0) ? base + stuck_k : -1;
      hang_sel  = (hang_k >= 0) ? base + hang_k : -1;
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      base_addr  = AW'(base);
      word_count = CW'(cnt);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      base_addr  = AW'(63);     // R1: changes after capture have no effect
      word_count = '1;

      fork
         begin
            for (int i = 0; i < cnt && !over; i++) begin
               if (i % 3 == 1) @(negedge clk);
               s_valid = 1'b1;
               s_data  = wd[i];
               while (!over) begin
                  if (s_ready) begin
                     @(negedge clk);
                     break;
                  end
                  @(negedge clk);
               end
               s_valid = 1'b0;
            end
         end
         begin
            for (int c = 0; c < 4000; c++) begin
               if (done) begin
                  got_done = 1;
                  done_cyc = c;
                  break;
               end
               if (inject && c == 6) begin
                  start = 1'b1;   // R1: start while busy
                  base_addr  = AW'(base + 9);
                  word_count = CW'(2);
               end else start = 1'b0;
               @(negedge clk);
            end
            start = 1'b0;
            over = 1;
            @(negedge clk);
            width_ok = !done;
         end
      join

      chk(got_done, "R7 done seen", int'(got_done), 1);
      chk(width_ok, "R7 done width one cycle", int'(!width_ok), 0);

      if (stuck_k >= 0)     last_w = stuck_k;
      else if (hang_k >= 0) last_w = hang_k;
      else                  last_w = cnt - 1;

      if (cnt == 0) begin
         n_exp = 0;
         chk(done_cyc == 0, "R9 zero count done latency", done_cyc, 0);
      end else begin
         ea[0] = AW'(12'h555); ed[0] = 16'h00AA;
         ea[1] = AW'(12'h2AA); ed[1] = 16'h0055;
         ea[2] = AW'(12'h555); ed[2] = 16'h0020;
         k = 3;
         for (int w = 0; w <= last_w; w++) begin
            ea[k] = AW'(base + w); ed[k] = 16'h00A0; k++;
            ea[k] = AW'(base + w); ed[k] = wd[w];    k++;
         end
         ea[k] = '0; ed[k] = 16'h0090; k++;
         ea[k] = '0; ed[k] = 16'h0000; k++;
         n_exp = k;
      end

      chk(nlog == n_exp, "R6/R7 write count", nlog, n_exp);
      for (int j = 0; j < n_exp && j < nlog; j++)
         if (bad_idx < 0 && (log_a[j] !== ea[j] || log_d[j] !== ed[j])) bad_idx = j;
      if (bad_idx >= 0)
         chk(0, "R1/R2/R3/R6/R7 write sequence entry data",
             int'(log_d[bad_idx]), int'(ed[bad_idx]));
      else
         chk(1, "R2/R3 write sequence", 0, 0);

      chk(bad_reads == 0, "R4 poll address", bad_reads, 0);
      chk(err_verify == (stuck_k >= 0), "R5 err_verify", int'(err_verify), int'(stuck_k >= 0));
      chk(err_timeout == (hang_k >= 0), "R8 err_timeout", int'(err_timeout), int'(hang_k >= 0));
      if (stuck_k >= 0 || hang_k >= 0)
         chk(int'(err_addr) == base + last_w, "R5/R8 err_addr", int'(err_addr), base + last_w);
      else
         chk(err_addr == '0, "R10 err_addr cleared", int'(err_addr), 0);
      if (hang_k >= 0)
         chk(hang_reads == PM, "R8 poll count before timeout", hang_reads, PM);
      if (stuck_k < 0 && hang_k < 0)
         for (int i = 0; i < cnt; i++)
            chk(mem[(base + i) % 64] == wd[i], "R6 memory content",
                int'(mem[(base + i) % 64]), int'(wd[i]));
      if (stuck_k >= 0 || hang_k >= 0) begin
         repeat (3) @(negedge clk);
         chk(err_verify == (stuck_k >= 0) && err_timeout == (hang_k >= 0) && !busy,
             "R10 error held while idle", int'(err_verify) + 2 * int'(err_timeout),
             int'(stuck_k >= 0) + 2 * int'(hang_k >= 0));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!busy && !done && !s_ready && !bus_we && !bus_re && !err_verify && !err_timeout,
          "R11 reset state", int'(busy) + int'(done) + int'(bus_we) + int'(bus_re), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !s_ready, "R11 idle after reset", int'(busy), 0);

      // sweep: bases x counts x program latencies
      foreach (base_addr[b]) begin end
      for (int bi = 0; bi < 3; bi++)
         for (int c = 1; c <= 5; c++)
            for (int d = 0; d < 4; d++)
               run_job((bi == 0) ? 2 : (bi == 1) ? 20 : 41, c, d, -1, -1, 0);

      run_job(7, 0, 0, -1, -1, 0);   // R9
      run_job(10, 4, 1, 0, -1, 0);   // R5 first word fails
      run_job(30, 4, 2, 2, -1, 0);   // R5 middle word fails
      run_job(5, 3, 1, -1, -1, 1);   // R1 start while busy, R10 clear
      run_job(12, 3, 0, -1, 0, 0);   // R8 first word hangs
      run_job(50, 3, 1, -1, 1, 0);   // R8 second word hangs
      run_job(44, 2, 3, -1, -1, 0);  // R10 clear after timeout

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule